// File: doc/BRIEF.md
# Duplicated register file with parity repair

This block is an integer register file with two read ports and one write port, built from two identical two-port memories that share their write side. Every stored word carries one even-parity bit computed at write time. Read port A is served by copy 0 and read port B by copy 1. Words are captured at the clock edge after the address is presented, and their parity is checked in the following cycle, alongside execution of the instruction that asked for them, so the parity logic does not lengthen the read path.

When a checked word fails parity, the block asks the surrounding pipeline to flush and restart at the failing instruction. During that flush it reads the same register from the other copy, checks its parity, and writes it into the failing copy in place of the instruction's normal result write. It also increments a repair counter. If the source word is also bad, no repair is made and an uncorrectable-error trap is raised. One register is repaired per restart. An instruction with several bad operands is restarted once per bad operand.

A fault-injection input flips chosen stored bits in one copy. It is used to exercise the repair path.

Top module: `regfile_dup`

## Requirements
- R1: After reset every word of both copies reads as zero with correct parity. `flush` and `uncorr_trap` are low and `fix_count` is zero.
- R2: An address presented on a read port in cycle n shows its stored data on that port's data output in cycle n+1. Port A reads copy 0 and port B reads copy 1. A read and a write to the same address in the same cycle return the old contents.
- R3: A write stores the data plus an even-parity bit (bit 32 is the XOR of the data bits) into both copies. A word read in cycle n is checked in cycle n+1. If the word is checked and its parity fails, `flush` is high in that cycle n+1.
- R4: Once raised, `flush` stays high for exactly four consecutive cycles. Words read during those four cycles are never checked.
- R5: A parity error from port A is repaired by copying the word from copy 1 into copy 0, and an error from port B by copying copy 0 into copy 1. The repair write happens at the end of the third flush cycle. Re-reading the register after the flush returns the correct data with no new error.
- R6: If the source word is also bad, `uncorr_trap` is high for the third flush cycle only. In that case no repair is written and `fix_count` does not change.
- R7: `fix_count` grows by exactly one for each successful repair. The new value is visible from the fourth flush cycle, and the counter changes at no other time.
- R8: If both ports show errors in the same check cycle, port A's word is repaired first. Port B's error is found again when the reads are reissued after the restart, and it is repaired by a second restart.
- R9: A write requested while `flush` is high is ignored and changes neither copy.
- R10: An injection flips, in the selected copy (`inj_copy`: 0 or 1), the stored bits of `inj_addr` that are set in `inj_flip`, at the clock edge. Parity is not recomputed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_addr | input | 8 | Read port A address |
| rd_b_addr | input | 8 | Read port B address |
| rd_a_data | output | 32 | Port A data, one cycle after the address |
| rd_b_data | output | 32 | Port B data, one cycle after the address |
| wr_en | input | 1 | Write request |
| wr_addr | input | 8 | Write address |
| wr_data | input | 32 | Write data |
| inj_en | input | 1 | Fault-injection strobe |
| inj_copy | input | 1 | Copy selected for injection |
| inj_addr | input | 8 | Word selected for injection |
| inj_flip | input | 33 | Bit mask to flip, parity bit included |
| flush | output | 1 | Flush and restart request, four cycles |
| uncorr_trap | output | 1 | Uncorrectable register error |
| fix_count | output | 16 | Number of successful repairs |

## Verification
The assertions assume that all addresses stay below the word count. They also assume that an injection never hits the same word and copy that a write or a repair updates on the same edge, since the result of such a collision is left unspecified. The bench keeps injections away from any word being written in that cycle. It injects only after a cycle in which `flush` was low, which keeps them clear of the repair edge. Its random phase draws every address inside the valid range.

// File: rtl/regfile_dup.sv
module regfile_dup #(
  parameter int WORDS = 136,
  parameter int WIDTH = 32,
  parameter int CNT_W = 16,
  localparam int AW = $clog2(WORDS),
  localparam int EW = WIDTH + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_a_addr,
  input  logic [AW-1:0]    rd_b_addr,
  output logic [WIDTH-1:0] rd_a_data,
  output logic [WIDTH-1:0] rd_b_data,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             inj_en,
  input  logic             inj_copy,
  input  logic [AW-1:0]    inj_addr,
  input  logic [EW-1:0]    inj_flip,
  output logic             flush,
  output logic             uncorr_trap,
  output logic [CNT_W-1:0] fix_count
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_CHK, S_WB} state_t;

  state_t          st;
  logic            chk_v;
  logic [AW-1:0]   a_q, b_q, fix_addr;
  logic            fix_dst;
  logic [EW-1:0]   fix_word;
  logic            err_a, err_b, det, repair, wr_ok;
  logic [EW-1:0]   wr_word;

  assign wr_word = {^wr_data, wr_data};

  for (genvar c = 0; c < 2; c++) begin : g_copy
    logic [EW-1:0] mem [WORDS];
    logic [EW-1:0] rq;
    logic [EW-1:0] src;
    logic [AW-1:0] raddr;

    assign raddr = (c == 0) ? rd_a_addr : rd_b_addr;
    assign src   = mem[fix_addr];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        rq <= '0;
      end else begin
        rq <= mem[raddr];
        if (wr_ok) mem[wr_addr] <= wr_word;
        if (repair && fix_dst == 1'(c)) mem[fix_addr] <= fix_word;
        if (inj_en && inj_copy == 1'(c)) mem[inj_addr] <= mem[inj_addr] ^ inj_flip;
      end
    end
  end

  assign rd_a_data   = g_copy[0].rq[WIDTH-1:0];
  assign rd_b_data   = g_copy[1].rq[WIDTH-1:0];
  assign err_a       = ^g_copy[0].rq;
  assign err_b       = ^g_copy[1].rq;
  assign det         = chk_v && (err_a || err_b);
  assign flush       = det || (st != S_IDLE);
  assign wr_ok       = wr_en && !flush;
  assign repair      = (st == S_CHK) && !(^fix_word);
  assign uncorr_trap = (st == S_CHK) && (^fix_word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      chk_v     <= 1'b0;
      a_q       <= '0;
      b_q       <= '0;
      fix_addr  <= '0;
      fix_dst   <= 1'b0;
      fix_word  <= '0;
      fix_count <= '0;
    end else begin
      chk_v <= !flush;
      a_q   <= rd_a_addr;
      b_q   <= rd_b_addr;
      case (st)
        S_IDLE: if (det) begin
          st       <= S_RD;
          fix_dst  <= !err_a;
          fix_addr <= err_a ? a_q : b_q;
        end
        S_RD: begin
          fix_word <= fix_dst ? g_copy[0].src : g_copy[1].src;
          st       <= S_CHK;
        end
        S_CHK: begin
          if (repair) fix_count <= fix_count + 1'b1;
          st <= S_WB;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/regfile_dup_chk.sv
module regfile_dup_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             uncorr_trap,
  input logic [CNT_W-1:0] fix_count
);

  AST_FLUSH_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush) |=> flush ##1 flush ##1 flush ##1 !flush); // R4

  AST_TRAP_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    uncorr_trap |-> flush); // R6

  AST_TRAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    uncorr_trap |=> !uncorr_trap); // R6

  AST_TRAP_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    uncorr_trap |=> $stable(fix_count)); // R6

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fix_count) |-> fix_count == CNT_W'($past(fix_count) + 1'b1)); // R7

  AST_COUNT_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fix_count) |-> flush); // R7

endmodule

bind regfile_dup regfile_dup_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .uncorr_trap(uncorr_trap), .fix_count(fix_count)
);

// File: tb/regfile_dup_tb.sv
module regfile_dup_tb;
  localparam int CLK_P = 10;
  localparam int WORDS = 136;
  localparam int AW = 8;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] rd_a_addr = 0, rd_b_addr = 0, wr_addr = 0, inj_addr = 0;
  logic [31:0] wr_data = 0, rd_a_data, rd_b_data;
  logic wr_en = 0, inj_en = 0, inj_copy = 0, flush, uncorr_trap;
  logic [32:0] inj_flip = 0;
  logic [15:0] fix_count;

  int errors = 0, checks = 0;
  bit run = 0, done = 0;

  always #(CLK_P/2) clk = ~clk;

  regfile_dup u_dut (.*);

  // behavioural reference
  logic [32:0] m0 [WORDS], m1 [WORDS];
  logic [32:0] qa, qb, fw;
  logic [AW-1:0] pa, pb, fa;
  logic chkv, fd;
  int ph, cnt;

  function automatic logic [32:0] enc(input logic [31:0] d);
    return {^d, d};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) begin m0[i] = 0; m1[i] = 0; end
      qa = 0; qb = 0; fw = 0; pa = 0; pb = 0; fa = 0; chkv = 0; fd = 0; ph = 0; cnt = 0;
    end else begin
      logic d, fl;
      logic [32:0] na, nb;
      int nph;
      d  = chkv && ((^qa) || (^qb));
      fl = d || ph != 0;
      na = m0[rd_a_addr];
      nb = m1[rd_b_addr];
      nph = 0;
      if (ph == 2 && !(^fw)) begin
        if (fd) m1[fa] = fw; else m0[fa] = fw;
        cnt++;
      end
      if (ph == 1) begin fw = fd ? m0[fa] : m1[fa]; nph = 2; end
      if (ph == 2) nph = 3;
      if (d) begin
        nph = 1;
        fd = !(^qa);
        fa = (^qa) ? pa : pb;
      end
      if (wr_en && !fl) begin m0[wr_addr] = enc(wr_data); m1[wr_addr] = enc(wr_data); end
      if (inj_en) begin
        if (inj_copy) m1[inj_addr] = m1[inj_addr] ^ inj_flip;
        else m0[inj_addr] = m0[inj_addr] ^ inj_flip;
      end
      ph = nph; qa = na; qb = nb; pa = rd_a_addr; pb = rd_b_addr; chkv = !fl;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && run) begin
    logic ef, et;
    ef = (chkv && ((^qa) || (^qb))) || ph != 0;
    et = (ph == 2) && (^fw);
    chk(rd_a_data === qa[31:0], "R2", "port A data", rd_a_data, qa[31:0]);
    chk(rd_b_data === qb[31:0], "R2", "port B data", rd_b_data, qb[31:0]);
    chk(flush === ef, "R4", "flush", flush, ef);
    chk(uncorr_trap === et, "R6", "trap", uncorr_trap, et);
    chk(fix_count === 16'(cnt), "R7", "count", fix_count, cnt);
  end

  task automatic tick;
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; tick; wr_en = 0;
  endtask

  task automatic inj(input logic c, input logic [AW-1:0] a, input logic [32:0] m);
    inj_en = 1; inj_copy = c; inj_addr = a; inj_flip = m; tick; inj_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1; run = 1;
    tick;
    // R1 reset state
    chk(flush === 0 && uncorr_trap === 0, "R1", "ctl after reset", {flush, uncorr_trap}, 0);
    chk(fix_count === 0, "R1", "count after reset", fix_count, 0);
    chk(rd_a_data === 0 && rd_b_data === 0, "R1", "words after reset", rd_a_data, 0);

    for (int i = 1; i < 20; i++) wr(AW'(i), 32'h1000_0000 + i * 32'h0101_0101);
    // R2 read latency and read-before-write
    rd_a_addr = 3; rd_b_addr = 4; tick;
    chk(rd_a_data === 32'h1303_0303, "R2", "A reads 3", rd_a_data, 32'h1303_0303);
    chk(rd_b_data === 32'h1404_0404, "R2", "B reads 4", rd_b_data, 32'h1404_0404);
    rd_a_addr = 6; wr_en = 1; wr_addr = 6; wr_data = 32'hCAFE_0006; tick; wr_en = 0;
    chk(rd_a_data === 32'h1606_0606, "R2", "old data on collision", rd_a_data, 32'h1606_0606);
    tick;
    chk(rd_a_data === 32'hCAFE_0006, "R2", "new data next read", rd_a_data, 32'hCAFE_0006);

    // R3 / R4 / R5 / R7 / R9: port A repair
    rd_a_addr = 0; rd_b_addr = 0; tick;
    inj(0, 5, 33'h8);
    rd_a_addr = 5; tick;
    chk(flush === 1, "R3", "flush one cycle after read", flush, 1);
    wr_en = 1; wr_addr = 7; wr_data = 32'hDEAD_BEEF; tick; wr_en = 0;
    chk(flush === 1, "R4", "flush cycle 2", flush, 1);
    tick;
    chk(uncorr_trap === 0, "R5", "no trap on good source", uncorr_trap, 0);
    tick;
    chk(fix_count === 1, "R7", "count after repair", fix_count, 1);
    tick;
    chk(flush === 0, "R4", "flush ends after four", flush, 1'b0);
    tick;
    chk(flush === 0 && rd_a_data === 32'h1505_0505, "R5", "A repaired", rd_a_data, 32'h1505_0505);
    rd_a_addr = 7; rd_b_addr = 7; tick; tick;
    chk(rd_a_data === 32'h1707_0707 && rd_b_data === 32'h1707_0707, "R9", "write in flush ignored",
        rd_b_data, 32'h1707_0707);

    // R5 port B repair, R10 parity-bit flip
    rd_a_addr = 0; rd_b_addr = 0; tick;
    inj(1, 9, 33'h1_0000_0000);
    rd_b_addr = 9; tick;
    chk(flush === 1, "R10", "parity bit flip detected", flush, 1);
    repeat (5) tick;
    chk(flush === 0 && rd_b_data === 32'h1909_0909 && fix_count === 2, "R5", "B repaired",
        rd_b_data, 32'h1909_0909);

    // R6 both copies bad
    rd_b_addr = 0; tick;
    inj(0, 11, 33'h1); inj(1, 11, 33'h2);
    rd_a_addr = 11; tick; tick;
    rd_a_addr = 0; tick;
    chk(uncorr_trap === 1, "R6", "trap in third flush cycle", uncorr_trap, 1);
    tick;
    chk(uncorr_trap === 0 && fix_count === 2, "R6", "no repair on trap", fix_count, 2);
    repeat (3) tick;
    wr(11, 32'h1b0b_0b0b);

    // R8 both ports at once
    inj(0, 12, 33'h4); inj(1, 13, 33'h40);
    rd_a_addr = 12; rd_b_addr = 13; tick;
    chk(flush === 1, "R8", "dual error flush", flush, 1);
    repeat (3) tick;
    chk(fix_count === 3, "R8", "A repaired first", fix_count, 3);
    tick; tick;
    chk(flush === 1 && rd_a_data === 32'h1c0c_0c0c, "R8", "B found again", flush, 1);
    repeat (3) tick;
    chk(fix_count === 4, "R8", "B repaired second", fix_count, 4);
    repeat (3) tick;
    chk(flush === 0 && rd_b_data === 32'h1d0d_0d0d, "R8", "B data clean", rd_b_data, 32'h1d0d_0d0d);

    // random traffic with occasional injections
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] wa;
      wa = AW'($urandom_range(WORDS - 1));
      rd_a_addr = AW'($urandom_range(WORDS - 1));
      rd_b_addr = AW'($urandom_range(WORDS - 1));
      wr_en = ($urandom_range(3) == 0);
      wr_addr = wa;
      wr_data = $urandom;
      inj_en = 0;
      if (!flush && $urandom_range(40) == 0) begin
        inj_en = 1;
        inj_copy = 1'($urandom_range(1));
        inj_addr = AW'($urandom_range(WORDS - 1));
        inj_flip = 33'h1 << $urandom_range(32);
        if (wr_en && inj_addr == wa) inj_en = 0;
      end
      tick;
    end
    wr_en = 0; inj_en = 0;
    tick; tick;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule